// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is the device-side command logic of a byte-wide parallel NOR flash. A host issues memory-mapped writes and reads. The block spots unlock-prefixed command sequences among those writes and starts a byte program, a sector erase, an erase suspend or resume, an identification mode, or a return to normal reads. A small on-chip register file stands in for the flash cells. It obeys the flash rules: programming can only clear bits, and an erase sets a whole sector back to ones.

While a program or erase runs, every read returns a status byte instead of array data. Busy times are parameterised cycle counts. The `unlock_i` input gates all command writes. The `err_inj_i` input forces a running operation into the failed state so that the error path can be exercised.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A program is four accepted writes: 0xAA at low-12-bit address 0xAAA, 0x55 at 0x555, 0xA0 at 0xAAA, then the data byte at the target address. Only address bits [11:0] are compared in the command cycles.
- R2: A read (`rd_i`), or an accepted write that does not match the next expected cycle, during an unfinished sequence returns the block to read-array mode with the array unchanged.
- R3: `busy_o` is high for exactly PROG_CYC cycles after the final program write. After that, the target byte (index = address bits [5:0]) reads old AND data.
- R4: A program whose data has a 1 where the stored bit is 0 enters a failed state. In that state `busy_o` is 0, reads return status with bit 5 = 1, and the array is not changed.
- R5: An erase is 0xAA@AAA, 0x55@555, 0x80@AAA, 0xAA@AAA, 0x55@555, then 0x30 at any address. After ERASE_CYC busy cycles, all 16 bytes of the sector selected by address bits [5:4] read 0xFF. Other sectors are unchanged.
- R6: While busy, a read returns a status byte with these fields: bit 7 = inverse of the programmed data bit 7 (0 during erase), bit 6 toggling on each read, bit 5 = 0, and bits 4..0 = 0.
- R7: Writing 0xF0 with low 12 address bits equal to 0 leaves the failed state or identification mode and returns to read-array mode. The same write is ignored while a program or erase is busy.
- R8: Writing 0xB0 during a busy erase suspends it: `busy_o` drops, array reads work again, and the erase timer freezes. Writing 0x30 resumes the erase, which then completes.
- R9: The sequence 0xAA@AAA, 0x55@555, 0x90@AAA enters identification mode. In that mode a read at low-12 offset 0 returns MFR_ID, offset 2 returns DEV_ID, and any other offset returns 0x00.
- R10: While `unlock_i` is low, writes are ignored: they neither advance nor abort a sequence.
- R11: `err_inj_i` high during a busy operation moves the block to the failed state, with status bit 5 = 1.
- R12: After reset the block is in read-array mode, `busy_o` is 0, and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unlock_i | input | 1 | Write enable gate for commands |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| err_inj_i | input | 1 | Force failure of a running operation |
| rdata_o | output | 8 | Read data: array, status or ID byte |
| busy_o | output | 1 | Program or erase running |

## Verification
The assertions take for granted that `rd_i` and `wr_i` are never high in the same cycle. They also assume each strobe lasts one clock, so one host access is counted once. The bench drives every access from a task that raises a single strobe for exactly one clock and separates accesses by an idle cycle. It raises `err_inj_i` only while an operation is busy. Suspend and reset writes are placed well before the erase timer expires, so no command coincides with a completion.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int CMD_BITS = 12;

  typedef enum logic [3:0] {
    S_READ, S_C1, S_C2, S_PGM, S_E1, S_E2, S_E3,
    S_AUTO, S_PBUSY, S_EBUSY, S_ESUSP, S_FAIL
  } nor_st_e;

  localparam logic [7:0] K_UNLK_A = 8'hAA;
  localparam logic [7:0] K_UNLK_B = 8'h55;
  localparam logic [7:0] K_PROG   = 8'hA0;
  localparam logic [7:0] K_ERSET  = 8'h80;
  localparam logic [7:0] K_ERGO   = 8'h30;
  localparam logic [7:0] K_SUSP   = 8'hB0;
  localparam logic [7:0] K_IDENT  = 8'h90;
  localparam logic [7:0] K_RST    = 8'hF0;

  localparam logic [CMD_BITS-1:0] ADR_A   = 12'hAAA;
  localparam logic [CMD_BITS-1:0] ADR_B   = 12'h555;
  localparam logic [CMD_BITS-1:0] ADR_RST = 12'h000;
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic sel_ers_i,
  input  logic run_i,
  output logic done_o
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= sel_ers_i ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
    else if (run_i)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(1));

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int IDX_W  = 6,
  parameter int SECT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  input  logic             pgm_en_i,
  input  logic             ers_en_i,
  input  logic [IDX_W-1:0] tgt_idx_i,
  input  logic [7:0]       tgt_data_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (pgm_en_i) begin
      mem_q[tgt_idx_i] <= mem_q[tgt_idx_i] & tgt_data_i;
    end else if (ers_en_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (IDX_W'(i) >> SECT_W == tgt_idx_i >> SECT_W) mem_q[i] <= 8'hFF;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  AST_ONE_ARRAY_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pgm_en_i && ers_en_i)); // R5
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                unlock_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [CMD_BITS-1:0] alo_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [7:0]          wdata_i,
  input  logic [7:0]          arr_rd_i,
  input  logic                err_inj_i,
  input  logic                done_i,
  output nor_st_e             st_o,
  output logic                load_o,
  output logic                sel_ers_o,
  output logic                run_o,
  output logic                pgm_go_o,
  output logic                ers_go_o,
  output logic [IDX_W-1:0]    tgt_idx_o,
  output logic [7:0]          tgt_data_o,
  output logic [7:0]          stat_o
);
  nor_st_e st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] dat_q;
  logic b7_q, tog_q, lat_p, lat_e;

  logic wr_ok, at_a, at_b, rst_hit, viol;
  assign wr_ok   = wr_i && unlock_i;
  assign at_a    = alo_i == ADR_A;
  assign at_b    = alo_i == ADR_B;
  assign rst_hit = wdata_i == K_RST && alo_i == ADR_RST;
  assign viol    = |(~arr_rd_i & wdata_i);

  always_comb begin
    st_d = st_q; load_o = 1'b0; pgm_go_o = 1'b0; ers_go_o = 1'b0;
    lat_p = 1'b0; lat_e = 1'b0;
    unique case (st_q)
      S_READ:  if (wr_ok && wdata_i == K_UNLK_A && at_a) st_d = S_C1;
      S_C1:    if (rd_i) st_d = S_READ;
               else if (wr_ok) st_d = (wdata_i == K_UNLK_B && at_b) ? S_C2 : S_READ;
      S_C2:    if (rd_i) st_d = S_READ;
               else if (wr_ok) begin
                 if (at_a && wdata_i == K_PROG)       st_d = S_PGM;
                 else if (at_a && wdata_i == K_ERSET) st_d = S_E1;
                 else if (at_a && wdata_i == K_IDENT) st_d = S_AUTO;
                 else                                 st_d = S_READ;
               end
      S_PGM:   if (rd_i) st_d = S_READ;
               else if (wr_ok) begin
                 lat_p = 1'b1;
                 if (viol) st_d = S_FAIL;
                 else begin st_d = S_PBUSY; load_o = 1'b1; end
               end
      S_E1:    if (rd_i) st_d = S_READ;
               else if (wr_ok) st_d = (wdata_i == K_UNLK_A && at_a) ? S_E2 : S_READ;
      S_E2:    if (rd_i) st_d = S_READ;
               else if (wr_ok) st_d = (wdata_i == K_UNLK_B && at_b) ? S_E3 : S_READ;
      S_E3:    if (rd_i) st_d = S_READ;
               else if (wr_ok) begin
                 if (wdata_i == K_ERGO) begin
                   st_d = S_EBUSY; load_o = 1'b1; lat_e = 1'b1;
                 end else st_d = S_READ;
               end
      S_AUTO, S_FAIL: if (wr_ok && rst_hit) st_d = S_READ;
      S_PBUSY: if (err_inj_i) st_d = S_FAIL;
               else if (done_i) begin pgm_go_o = 1'b1; st_d = S_READ; end
      S_EBUSY: if (err_inj_i) st_d = S_FAIL;
               else if (done_i) begin ers_go_o = 1'b1; st_d = S_READ; end
               else if (wr_ok && wdata_i == K_SUSP) st_d = S_ESUSP;
      S_ESUSP: if (wr_ok && wdata_i == K_ERGO) st_d = S_EBUSY;
      default: st_d = S_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_READ; idx_q <= '0; dat_q <= 8'hFF; b7_q <= 1'b0; tog_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (lat_p) begin idx_q <= idx_i; dat_q <= wdata_i; b7_q <= ~wdata_i[7]; end
      if (lat_e) begin idx_q <= idx_i; b7_q <= 1'b0; end
      if (rd_i && (st_q == S_PBUSY || st_q == S_EBUSY || st_q == S_FAIL)) tog_q <= ~tog_q;
    end
  end

  assign st_o       = st_q;
  assign sel_ers_o  = st_q == S_E3;
  assign run_o      = st_q == S_PBUSY || st_q == S_EBUSY;
  assign tgt_idx_o  = idx_q;
  assign tgt_data_o = dat_q;
  assign stat_o     = {b7_q, tog_q, st_q == S_FAIL, 5'b0};

  AST_READ_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && st_q inside {S_C1, S_C2, S_PGM, S_E1, S_E2, S_E3}) |=> st_q == S_READ); // R2
  AST_FAIL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FAIL && !(wr_ok && rst_hit)) |=> st_q == S_FAIL); // R4
  AST_RST_IGN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PBUSY && !done_i && !err_inj_i) |=> st_q == S_PBUSY); // R7
  AST_ERR_TO_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && err_inj_i) |=> st_q == S_FAIL); // R11
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          IDX_W     = 6,
  parameter int          SECT_W    = 4,
  parameter int          PROG_CYC  = 8,
  parameter int          ERASE_CYC = 32,
  parameter logic [7:0]  MFR_ID    = 8'hC2,
  parameter logic [7:0]  DEV_ID    = 8'hDA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unlock_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              err_inj_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  nor_st_e st;
  logic load, sel_ers, run, done, pgm_go, ers_go;
  logic [IDX_W-1:0] tgt_idx;
  logic [7:0] tgt_data, stat, arr_rd;
  logic [CMD_BITS-1:0] alo;
  logic unused_hi;

  assign alo       = addr_i[CMD_BITS-1:0];
  assign unused_hi = ^addr_i[ADDR_W-1:CMD_BITS];

  nor_cmd_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni, .unlock_i, .wr_i, .rd_i,
    .alo_i(alo), .idx_i(addr_i[IDX_W-1:0]), .wdata_i, .arr_rd_i(arr_rd),
    .err_inj_i, .done_i(done), .st_o(st), .load_o(load), .sel_ers_o(sel_ers),
    .run_o(run), .pgm_go_o(pgm_go), .ers_go_o(ers_go),
    .tgt_idx_o(tgt_idx), .tgt_data_o(tgt_data), .stat_o(stat)
  );

  nor_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .sel_ers_i(sel_ers), .run_i(run), .done_o(done)
  );

  nor_cell_array #(.IDX_W(IDX_W), .SECT_W(SECT_W)) u_arr (
    .clk_i, .rst_ni, .rd_idx_i(addr_i[IDX_W-1:0]), .rd_data_o(arr_rd),
    .pgm_en_i(pgm_go), .ers_en_i(ers_go), .tgt_idx_i(tgt_idx), .tgt_data_i(tgt_data)
  );

  always_comb begin
    if (st == S_PBUSY || st == S_EBUSY || st == S_FAIL) rdata_o = stat;
    else if (st == S_AUTO)
      rdata_o = (alo == 12'h000) ? MFR_ID : (alo == 12'h002) ? DEV_ID : 8'h00;
    else rdata_o = arr_rd;
  end

  assign busy_o = run;

  AST_ERS_STAT_B7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_EBUSY && rd_i) |-> !rdata_o[7]); // R6
  AST_BUSY_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i && unlock_i)); // R10
endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
  localparam int PC = 8;
  localparam int EC = 32;
  localparam logic [7:0] MFR = 8'hC2;
  localparam logic [7:0] DEV = 8'hDA;

  logic clk = 1'b0, rst_n = 1'b0, unlock = 1'b1, wr = 1'b0, rd = 1'b0, err_inj = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_decoder u_nor_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .unlock_i(unlock), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .err_inj_i(err_inj), .rdata_o(rdata), .busy_o(busy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); rd = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_prog(input logic [15:0] hi, input logic [15:0] a, input logic [7:0] d);
    wr_b(hi | 16'h0AAA, 8'hAA); wr_b(hi | 16'h0555, 8'h55);
    wr_b(hi | 16'h0AAA, 8'hA0); wr_b(a, d);
  endtask

  task automatic start_erase(input logic [15:0] a);
    wr_b(16'h0AAA, 8'hAA); wr_b(16'h0555, 8'h55); wr_b(16'h0AAA, 8'h80);
    wr_b(16'h0AAA, 8'hAA); wr_b(16'h0555, 8'h55); wr_b(a, 8'h30);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R12 busy after reset", {7'b0, busy}, 8'h00);
    rd_b(16'h0000, v); check("R12 array byte 0", v, 8'hFF);
    rd_b(16'h003F, v); check("R12 array byte 63", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v;
    do_prog(16'h7000, 16'h0005, 8'h3C);   // upper bits set on command cycles, R1
    check("R3 busy right after final write", {7'b0, busy}, 8'h01);
    repeat (PC - 1) @(negedge clk);
    check("R3 busy at last busy cycle", {7'b0, busy}, 8'h01);
    @(negedge clk);
    check("R3 idle after PROG_CYC", {7'b0, busy}, 8'h00);
    rd_b(16'h0005, v); check("R1 programmed byte", v, 8'h3C);
    do_prog(16'h0000, 16'h0005, 8'h0C); wait_idle();
    rd_b(16'h0005, v); check("R3 AND of old and new", v, 8'h0C);
  endtask

  task automatic t_status();
    logic [7:0] s1, s2, v;
    do_prog(16'h0000, 16'h0010, 8'h5A);
    rd_b(16'h0010, s1); rd_b(16'h0010, s2);
    check("R6 bit7 inverse of data", {7'b0, s1[7]}, 8'h01);
    check("R6 bit5 low while running", {7'b0, s1[5]}, 8'h00);
    check("R6 low bits zero", {3'b0, s1[4:0]}, 8'h00);
    check("R6 bit6 toggles", {7'b0, s1[6] ^ s2[6]}, 8'h01);
    wait_idle();
    rd_b(16'h0010, v); check("R3 byte after status reads", v, 8'h5A);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    wr_b(16'h0AAA, 8'hAA); wr_b(16'h0555, 8'h55);
    rd_b(16'h0000, v);
    wr_b(16'h0AAA, 8'hA0); wr_b(16'h0020, 8'h00);
    check("R2 no busy after read abort", {7'b0, busy}, 8'h00);
    rd_b(16'h0020, v); check("R2 array kept after read abort", v, 8'hFF);
    wr_b(16'h0AAA, 8'hAA); wr_b(16'h0556, 8'h55);
    wr_b(16'h0AAA, 8'hA0); wr_b(16'h0020, 8'h00);
    check("R2 no busy after bad address", {7'b0, busy}, 8'h00);
    rd_b(16'h0020, v); check("R2 array kept after bad address", v, 8'hFF);
  endtask

  task automatic t_violation();
    logic [7:0] v;
    do_prog(16'h0000, 16'h0005, 8'h30);   // 0x0C holds zeros at bits 5,4
    check("R4 busy low in fail", {7'b0, busy}, 8'h00);
    rd_b(16'h0005, v);
    check("R4 status bit5 set", {7'b0, v[5]}, 8'h01);
    check("R4 status bit7", {7'b0, v[7]}, 8'h01);
    wr_b(16'h3000, 8'hF0);
    rd_b(16'h0005, v); check("R7 reset exits fail, R4 array kept", v, 8'h0C);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    do_prog(16'h0000, 16'h0012, 8'h00); wait_idle();
    do_prog(16'h0000, 16'h0022, 8'h00); wait_idle();
    start_erase(16'h0015);
    rd_b(16'h0012, v); check("R6 erase status bit7 low", {7'b0, v[7]}, 8'h00);
    wr_b(16'h0000, 8'hF0);
    check("R7 reset ignored during erase", {7'b0, busy}, 8'h01);
    wait_idle();
    rd_b(16'h0012, v); check("R5 erased sector byte", v, 8'hFF);
    rd_b(16'h0022, v); check("R5 other sector kept", v, 8'h00);
  endtask

  task automatic t_suspend();
    logic [7:0] v;
    do_prog(16'h0000, 16'h001A, 8'h00); wait_idle();
    start_erase(16'h0010);
    wr_b(16'h0000, 8'hB0);
    check("R8 busy low when suspended", {7'b0, busy}, 8'h00);
    rd_b(16'h001A, v); check("R8 array read while suspended", v, 8'h00);
    repeat (2 * EC) @(negedge clk);
    rd_b(16'h001A, v); check("R8 timer frozen in suspend", v, 8'h00);
    wr_b(16'h0000, 8'h30);
    check("R8 busy after resume", {7'b0, busy}, 8'h01);
    wait_idle();
    rd_b(16'h001A, v); check("R8 erase completes after resume", v, 8'hFF);
  endtask

  task automatic t_autosel();
    logic [7:0] v;
    wr_b(16'h0AAA, 8'hAA); wr_b(16'h0555, 8'h55); wr_b(16'h0AAA, 8'h90);
    rd_b(16'h4000, v); check("R9 manufacturer id", v, MFR);
    rd_b(16'h0002, v); check("R9 device id", v, DEV);
    rd_b(16'h0001, v); check("R9 other offset", v, 8'h00);
    wr_b(16'h0000, 8'hF0);
    rd_b(16'h0002, v); check("R7 reset leaves id mode", v, 8'hFF);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    unlock = 1'b0;
    do_prog(16'h0000, 16'h0033, 8'h00);
    check("R10 locked writes start nothing", {7'b0, busy}, 8'h00);
    rd_b(16'h0033, v); check("R10 locked array kept", v, 8'hFF);
    unlock = 1'b1; wr_b(16'h0AAA, 8'hAA);
    unlock = 1'b0; wr_b(16'h0123, 8'h77);
    unlock = 1'b1; wr_b(16'h0555, 8'h55); wr_b(16'h0AAA, 8'hA0); wr_b(16'h0033, 8'h81);
    wait_idle();
    rd_b(16'h0033, v); check("R10 ignored write did not abort", v, 8'h81);
  endtask

  task automatic t_errinj();
    logic [7:0] v;
    do_prog(16'h0000, 16'h0034, 8'h0F);
    @(negedge clk); err_inj = 1'b1; @(negedge clk); err_inj = 1'b0;
    check("R11 busy drops on injected error", {7'b0, busy}, 8'h00);
    rd_b(16'h0034, v); check("R11 status bit5", {7'b0, v[5]}, 8'h01);
    wr_b(16'h0000, 8'hF0);
    rd_b(16'h0034, v); check("R11 array unchanged after abort", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_program(); t_status(); t_abort(); t_violation();
    t_erase(); t_suspend(); t_autosel(); t_unlock(); t_errinj();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule